// File: doc/BRIEF.md
# Four-Bank Interleaved Word Memory

This block is a word-addressed store of 2^22 words, each 32 bits wide, split across four equal banks. A mode input sets how an address is divided into a bank number and a row number. In high-order mode the two most significant address bits choose the bank, so each bank holds one contiguous quarter of the address space. In low-order mode the two least significant bits choose the bank, so consecutive words land in consecutive banks.

Two request ports share the banks. Port 0 has priority. It can issue a single read or write, or in low-order mode a read burst of one to four adjacent words. The burst is served from the banks in parallel and all of its words come back together. Port 1 issues single reads and writes. It is granted in the same cycle unless port 0 is using the bank it needs. If refused, the requester keeps its request asserted until it is granted. Reads return one clock after acceptance, and writes take effect at the clock edge. A depth parameter shrinks each bank for simulation without changing how addresses are split.

Top module: `ilv_mem_ctrl`

## Requirements
- R1: After synchronous active-low reset, `p0_rvalid`, `p1_rvalid`, `p0_lane_vld` and both read data outputs are zero.
- R2: With `mode_lo` = 0 (high-order mode), bank = address bits [21:20] and row = bits [19:0]. Example: address 2^20 is bank 1, row 0.
- R3: With `mode_lo` = 1 (low-order mode), bank = address bits [1:0] and row = bits [21:2]. Addresses 0..3 are banks 0..3 at row 0, and address 4 is bank 0, row 1.
- R4: An accepted read on either port raises that port's valid output on the next clock edge and presents the stored word at the same time.
- R5: A write is stored at the clock edge of acceptance. A read of the same address one cycle later returns the new value, and a write produces no read valid.
- R6: When both ports need the same bank in a cycle, port 0 is served and `p1_gnt` is 0. A port-1 request held into a cycle where port 0 leaves that bank is granted.
- R7: In low-order mode, a port-0 read with `p0_len` = N-1 (N = 1..4) returns words addr..addr+N-1 (modulo 2^22) on lanes 0..N-1 of `p0_rdata`. Lane k occupies bits [32k+31:32k]. `p0_lane_vld` has its low N bits set, and unused lanes read zero.
- R8: In high-order mode, `p0_len` is ignored. Only lane 0 returns data, `p0_lane_vld` = 0001, and port 0 holds only that one bank.
- R9: A port-1 request to a bank not covered by a concurrent port-0 burst is granted in the same cycle. A request to a covered bank is refused.
- R10: Changing `mode_lo` does not move stored data. The word written at bank b, row r under one mode is read back by any address that maps to bank b, row r under the other mode.
- R11: A port-1 write refused by arbitration leaves memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_lo | input | 1 | 1 = low-order interleave, 0 = high-order; change only when no request is active |
| p0_req | input | 1 | Port 0 request |
| p0_we | input | 1 | Port 0 write (1) or read (0) |
| p0_addr | input | 22 | Port 0 word address (first word of a burst) |
| p0_len | input | 2 | Port 0 burst length minus one (reads, low-order mode) |
| p0_wdata | input | 32 | Port 0 write data |
| p0_rvalid | output | 1 | Port 0 read data valid |
| p0_lane_vld | output | 4 | Which lanes of `p0_rdata` carry burst words |
| p0_rdata | output | 128 | Port 0 read data, lane k = word addr+k |
| p1_req | input | 1 | Port 1 request, held until granted |
| p1_we | input | 1 | Port 1 write (1) or read (0) |
| p1_addr | input | 22 | Port 1 word address |
| p1_wdata | input | 32 | Port 1 write data |
| p1_gnt | output | 1 | Port 1 request accepted this cycle |
| p1_rvalid | output | 1 | Port 1 read data valid |
| p1_rdata | output | 32 | Port 1 read data |

## Verification
The embedded properties check timing and shape on every cycle:
- each accepted read on either port gets its valid one cycle later, and a write never does;
- the number of live burst lanes matches the requested length in low-order mode and is exactly one in high-order mode;
- port 1 is refused only while port 0 is active;
- the mode input moves only while both ports are idle.

The address splits, the wrap across rows and across the top of the address space, the ordering of burst words, and the data contents all depend on the values stored. Likewise, that a refused write leaves memory unchanged and that stored data stays in place across a mode switch can only be shown by the bench's scenarios. The bench compares against its own model of bank and row placement.

// File: rtl/ilv_pkg.sv
// Shared types for the interleaved memory.
// Assumes: exactly two address-split modes exist.
package ilv_pkg;

    // How a word address is split into bank and row.
    typedef enum logic {
        MAP_HIGH = 1'b0,   // bank from the top address bits
        MAP_LOW  = 1'b1    // bank from the bottom address bits
    } map_e;

endpackage

// File: rtl/ilv_addr_map.sv
// Splits one word address into bank number and row number for the chosen mode.
// Assumes: ADDR_W > BANK_W; purely combinational.
module ilv_addr_map
    import ilv_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int BANK_W = 2,
    localparam int ROW_W = ADDR_W - BANK_W
) (
    input  map_e              mode,
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row
);

    // Select the bank field from the low or high end of the address.
    always_comb begin
        if (mode == MAP_LOW) begin
            bank = addr[BANK_W-1:0];
            row  = addr[ADDR_W-1:BANK_W];
        end else begin
            bank = addr[ADDR_W-1:ROW_W];
            row  = addr[ROW_W-1:0];
        end
    end

endmodule

// File: rtl/ilv_bank.sv
// One behavioural bank: synchronous RAM with a one-cycle registered read.
// Assumes: ROW_DEPTH is a power of two >= 2; rows beyond the depth fold onto
// the low row bits. Storage is not reset; only the read register is.
module ilv_bank #(
    parameter int DATA_W    = 32,
    parameter int ROW_W     = 20,
    parameter int ROW_DEPTH = 16,
    localparam int IDX_W    = $clog2(ROW_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              we,
    input  logic [ROW_W-1:0]  row,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [ROW_DEPTH];
    logic [IDX_W-1:0]  idx;

    assign idx = row[IDX_W-1:0];

    generate
        if (ROW_W > IDX_W) begin : g_fold
            logic unused_row_hi;
            assign unused_row_hi = ^row[ROW_W-1:IDX_W];
        end
    endgenerate

    // Store write data at the edge of acceptance.
    always_ff @(posedge clk) begin
        if (en && we) begin
            mem[idx] <= wdata;
        end
    end

    // Capture the addressed word on a read; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (en && !we) begin
            rdata <= mem[idx];
        end
    end

endmodule

// File: rtl/ilv_bank_arb.sv
// Fixed-priority bank arbiter: port 0 lanes claim their banks first, port 1
// gets its bank only if no port-0 lane holds it. Builds one command per bank.
// Assumes: active port-0 lanes always target distinct banks.
module ilv_bank_arb #(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int ROW_W     = 20,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] lane_act,
    input  logic [BANK_W-1:0]    lane_bank [NUM_BANKS],
    input  logic [ROW_W-1:0]     lane_row  [NUM_BANKS],
    input  logic                 p0_we,
    input  logic [DATA_W-1:0]    p0_wdata,
    input  logic                 p1_req,
    input  logic                 p1_we,
    input  logic [BANK_W-1:0]    p1_bank,
    input  logic [ROW_W-1:0]     p1_row,
    input  logic [DATA_W-1:0]    p1_wdata,
    output logic                 p1_gnt,
    output logic [NUM_BANKS-1:0] bk_en,
    output logic [NUM_BANKS-1:0] bk_we,
    output logic [ROW_W-1:0]     bk_row   [NUM_BANKS],
    output logic [DATA_W-1:0]    bk_wdata [NUM_BANKS]
);

    logic [NUM_BANKS-1:0] p0_hit;

    // Mark every bank claimed by an active port-0 lane.
    always_comb begin
        p0_hit = '0;
        for (int k = 0; k < NUM_BANKS; k++) begin
            if (lane_act[k]) begin
                p0_hit[lane_bank[k]] = 1'b1;
            end
        end
    end

    // Grant port 1 when its bank is free.
    assign p1_gnt = p1_req && !p0_hit[p1_bank];

    // Drive each bank from the winning port.
    always_comb begin
        bk_en = '0;
        bk_we = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            bk_row[b]   = '0;
            bk_wdata[b] = '0;
            for (int k = 0; k < NUM_BANKS; k++) begin
                if (lane_act[k] && lane_bank[k] == BANK_W'(b)) begin
                    bk_en[b]    = 1'b1;
                    bk_we[b]    = p0_we;
                    bk_row[b]   = lane_row[k];
                    bk_wdata[b] = p0_wdata;
                end
            end
            if (p1_gnt && p1_bank == BANK_W'(b)) begin
                bk_en[b]    = 1'b1;
                bk_we[b]    = p1_we;
                bk_row[b]   = p1_row;
                bk_wdata[b] = p1_wdata;
            end
        end
    end

    // R6: port 1 is only ever held off by port-0 activity.
    assert_stall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_req && !p1_gnt) |-> (lane_act != '0));

endmodule

// File: rtl/ilv_mem_ctrl.sv
// Four-bank interleaved word memory with a priority port (single access or
// parallel read burst) and a secondary port arbitrated per bank.
// Assumes: mode_lo changes only while both ports are idle; a refused port-1
// request is held by its requester; bursts are reads in low-order mode.
module ilv_mem_ctrl
    import ilv_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 22,
    parameter int NUM_BANKS = 4,
    parameter int ROW_DEPTH = 16,
    localparam int BANK_W   = $clog2(NUM_BANKS),
    localparam int ROW_W    = ADDR_W - BANK_W,
    localparam int LEN_W    = BANK_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        mode_lo,
    input  logic                        p0_req,
    input  logic                        p0_we,
    input  logic [ADDR_W-1:0]           p0_addr,
    input  logic [LEN_W-1:0]            p0_len,
    input  logic [DATA_W-1:0]           p0_wdata,
    output logic                        p0_rvalid,
    output logic [NUM_BANKS-1:0]        p0_lane_vld,
    output logic [NUM_BANKS*DATA_W-1:0] p0_rdata,
    input  logic                        p1_req,
    input  logic                        p1_we,
    input  logic [ADDR_W-1:0]           p1_addr,
    input  logic [DATA_W-1:0]           p1_wdata,
    output logic                        p1_gnt,
    output logic                        p1_rvalid,
    output logic [DATA_W-1:0]           p1_rdata
);

    map_e                 mode;
    logic [ADDR_W-1:0]    lane_addr [NUM_BANKS];
    logic [BANK_W-1:0]    lane_bank [NUM_BANKS];
    logic [ROW_W-1:0]     lane_row  [NUM_BANKS];
    logic [NUM_BANKS-1:0] lane_act;
    logic [BANK_W-1:0]    p1_bank;
    logic [ROW_W-1:0]     p1_row;
    logic [NUM_BANKS-1:0] bk_en;
    logic [NUM_BANKS-1:0] bk_we;
    logic [ROW_W-1:0]     bk_row   [NUM_BANKS];
    logic [DATA_W-1:0]    bk_wdata [NUM_BANKS];
    logic [DATA_W-1:0]    bk_rdata [NUM_BANKS];
    logic [NUM_BANKS-1:0] lane_vld_q;
    logic [BANK_W-1:0]    lane_bank_q [NUM_BANKS];
    logic                 p1_vld_q;
    logic [BANK_W-1:0]    p1_bank_q;

    assign mode = mode_lo ? MAP_LOW : MAP_HIGH;

    // One address decoder per port-0 lane, each on the address plus its lane offset.
    generate
        for (genvar k = 0; k < NUM_BANKS; k++) begin : g_lane
            assign lane_addr[k] = p0_addr + ADDR_W'(k);
            ilv_addr_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_map (
                .mode (mode),
                .addr (lane_addr[k]),
                .bank (lane_bank[k]),
                .row  (lane_row[k])
            );
        end
    endgenerate

    ilv_addr_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_map_p1 (
        .mode (mode),
        .addr (p1_addr),
        .bank (p1_bank),
        .row  (p1_row)
    );

    // Lane 0 follows every request; higher lanes only for low-order read bursts.
    always_comb begin
        for (int k = 0; k < NUM_BANKS; k++) begin
            lane_act[k] = p0_req && ((k == 0) ||
                          (mode == MAP_LOW && !p0_we && LEN_W'(k) <= p0_len));
        end
    end

    ilv_bank_arb #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .ROW_W     (ROW_W),
        .DATA_W    (DATA_W)
    ) u_arb (
        .clk      (clk),
        .rst_n    (rst_n),
        .lane_act (lane_act),
        .lane_bank(lane_bank),
        .lane_row (lane_row),
        .p0_we    (p0_we),
        .p0_wdata (p0_wdata),
        .p1_req   (p1_req),
        .p1_we    (p1_we),
        .p1_bank  (p1_bank),
        .p1_row   (p1_row),
        .p1_wdata (p1_wdata),
        .p1_gnt   (p1_gnt),
        .bk_en    (bk_en),
        .bk_we    (bk_we),
        .bk_row   (bk_row),
        .bk_wdata (bk_wdata)
    );

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            ilv_bank #(
                .DATA_W   (DATA_W),
                .ROW_W    (ROW_W),
                .ROW_DEPTH(ROW_DEPTH)
            ) u_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .en    (bk_en[b]),
                .we    (bk_we[b]),
                .row   (bk_row[b]),
                .wdata (bk_wdata[b]),
                .rdata (bk_rdata[b])
            );
        end
    endgenerate

    // Remember which bank each read lane used, to route data back next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_vld_q  <= '0;
            lane_bank_q <= '{default: '0};
            p1_vld_q    <= 1'b0;
            p1_bank_q   <= '0;
        end else begin
            lane_vld_q  <= p0_we ? '0 : lane_act;
            lane_bank_q <= lane_bank;
            p1_vld_q    <= p1_gnt && !p1_we;
            p1_bank_q   <= p1_bank;
        end
    end

    // Steer bank outputs onto the port-0 lanes; idle lanes read zero.
    generate
        for (genvar k = 0; k < NUM_BANKS; k++) begin : g_out
            assign p0_rdata[k*DATA_W +: DATA_W] =
                lane_vld_q[k] ? bk_rdata[lane_bank_q[k]] : '0;
        end
    endgenerate

    assign p0_rvalid   = |lane_vld_q;
    assign p0_lane_vld = lane_vld_q;
    assign p1_rvalid   = p1_vld_q;
    assign p1_rdata    = p1_vld_q ? bk_rdata[p1_bank_q] : '0;

    // R4: port-0 read answered on the next edge.
    assert_p0_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_req && !p0_we) |=> p0_rvalid);

    // R4: granted port-1 read answered on the next edge.
    assert_p1_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (p1_req && p1_gnt && !p1_we) |=> p1_rvalid);

    // R5: a port-0 write produces no read response.
    assert_write_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_req && p0_we) |=> !p0_rvalid);

    // R7: burst lane count equals the requested length.
    assert_lane_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_req && !p0_we && mode_lo) |=>
            ($countones(p0_lane_vld) == int'($past(p0_len)) + 1));

    // R8: high-order mode returns lane 0 only.
    assert_single_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (p0_req && !p0_we && !mode_lo) |=> (p0_lane_vld == 4'b0001));

    // R10: the split mode moves only while both ports are idle.
    assert_mode_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_lo) |-> (!p0_req && !p1_req));

endmodule

// File: tb/ilv_mem_ctrl_tb.sv
// Scoreboard bench: the driver pushes expected read results with their due
// cycle, and the monitor pops and compares them at each falling edge.
module ilv_mem_ctrl_tb;

    localparam int DEPTH = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_lo = 1'b1;
    logic         p0_req = 1'b0, p0_we = 1'b0;
    logic [21:0]  p0_addr = '0;
    logic [1:0]   p0_len = '0;
    logic [31:0]  p0_wdata = '0;
    logic         p0_rvalid;
    logic [3:0]   p0_lane_vld;
    logic [127:0] p0_rdata;
    logic         p1_req = 1'b0, p1_we = 1'b0;
    logic [21:0]  p1_addr = '0;
    logic [31:0]  p1_wdata = '0;
    logic         p1_gnt, p1_rvalid;
    logic [31:0]  p1_rdata;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit run = 0;

    typedef struct {
        int           due;
        logic [3:0]   mask;
        logic [127:0] data;
        string        tag;
    } exp_t;

    exp_t q0[$];
    exp_t q1[$];
    logic [31:0] mdl [4*DEPTH];

    always #10 clk = ~clk;   // 50 MHz

    ilv_mem_ctrl #(.ROW_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_lo(mode_lo),
        .p0_req(p0_req), .p0_we(p0_we), .p0_addr(p0_addr), .p0_len(p0_len),
        .p0_wdata(p0_wdata), .p0_rvalid(p0_rvalid), .p0_lane_vld(p0_lane_vld),
        .p0_rdata(p0_rdata), .p1_req(p1_req), .p1_we(p1_we), .p1_addr(p1_addr),
        .p1_wdata(p1_wdata), .p1_gnt(p1_gnt), .p1_rvalid(p1_rvalid),
        .p1_rdata(p1_rdata)
    );

    // Physical slot of an address, from the R2/R3 splits.
    function automatic int phys(logic [21:0] a, logic lo);
        int b, r;
        if (lo) begin b = int'(a[1:0]);   r = int'(a[21:2]);  end
        else    begin b = int'(a[21:20]); r = int'(a[19:0]);  end
        return b * DEPTH + (r % DEPTH);
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000) begin
            nfail++;
            $display("FAIL watchdog: run hung, actual cycle %0d expected < 20000", cyc);
            $display("[TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

    // Monitor: compare responses due this cycle, flag unexpected ones.
    always @(negedge clk) begin
        if (run) begin
            if (q0.size() > 0 && q0[0].due == cyc) begin
                exp_t e;
                e = q0.pop_front();
                nchk++;
                if (p0_rvalid !== 1'b1 || p0_lane_vld !== e.mask || p0_rdata !== e.data) begin
                    nfail++;
                    $display("FAIL %s p0: actual vld=%b lanes=%b data=%h expected lanes=%b data=%h",
                             e.tag, p0_rvalid, p0_lane_vld, p0_rdata, e.mask, e.data);
                end
            end else if (p0_rvalid !== 1'b0) begin
                nfail++;
                $display("FAIL R4 p0: actual rvalid=%b expected 0", p0_rvalid);
            end
            if (q1.size() > 0 && q1[0].due == cyc) begin
                exp_t e;
                e = q1.pop_front();
                nchk++;
                if (p1_rvalid !== 1'b1 || p1_rdata !== e.data[31:0]) begin
                    nfail++;
                    $display("FAIL %s p1: actual vld=%b data=%h expected data=%h",
                             e.tag, p1_rvalid, p1_rdata, e.data[31:0]);
                end
            end else if (p1_rvalid !== 1'b0) begin
                nfail++;
                $display("FAIL R4 p1: actual rvalid=%b expected 0", p1_rvalid);
            end
        end
    end

    // Driver: one cycle of stimulus on both ports; gexp < 0 skips the grant check.
    task automatic step(input bit r0, input bit w0, input logic [21:0] a0, input int n0,
                        input logic [31:0] d0, input bit r1, input bit w1,
                        input logic [21:0] a1, input logic [31:0] d1,
                        input int gexp, input string tag);
        @(negedge clk);
        p0_req = r0; p0_we = w0; p0_addr = a0; p0_len = 2'((n0 > 0) ? n0 - 1 : 0);
        p0_wdata = d0;
        p1_req = r1; p1_we = w1; p1_addr = a1; p1_wdata = d1;
        #1;
        if (gexp >= 0) begin
            nchk++;
            if (p1_gnt !== 1'(gexp)) begin
                nfail++;
                $display("FAIL %s p1_gnt: actual %b expected %0d", tag, p1_gnt, gexp);
            end
        end
        if (r0 && !w0) begin
            exp_t e;
            e.due = cyc + 1; e.mask = '0; e.data = '0; e.tag = tag;
            for (int k = 0; k < 4; k++) begin
                if (k == 0 || (mode_lo && k < n0)) begin
                    e.mask[k] = 1'b1;
                    e.data[k*32 +: 32] = mdl[phys(a0 + 22'(k), mode_lo)];
                end
            end
            q0.push_back(e);
        end
        if (r1 && !w1 && p1_gnt) begin
            exp_t e;
            e.due = cyc + 1; e.mask = 4'b0001; e.data = '0; e.tag = tag;
            e.data[31:0] = mdl[phys(a1, mode_lo)];
            q1.push_back(e);
        end
        if (r0 && w0) mdl[phys(a0, mode_lo)] = d0;
        if (r1 && w1 && p1_gnt) mdl[phys(a1, mode_lo)] = d1;
    endtask

    task automatic idle();
        step(0, 0, '0, 0, '0, 0, 0, '0, '0, -1, "idle");
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        p0_req = 0; p1_req = 0; mode_lo = m;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs quiet after reset
        nchk++;
        if (p0_rvalid !== 1'b0 || p1_rvalid !== 1'b0 || p0_lane_vld !== 4'b0 ||
            p0_rdata !== '0 || p1_rdata !== '0) begin
            nfail++;
            $display("FAIL R1 reset: actual vld=%b/%b lanes=%b expected all zero",
                     p0_rvalid, p1_rvalid, p0_lane_vld);
        end
        run = 1;

        // R3: fill addresses 0..31, both ports writing adjacent words in parallel
        for (int i = 0; i < 16; i++) begin
            step(1, 1, 22'(2*i), 1, 32'hA000_0000 + 32'(2*i),
                 1, 1, 22'(2*i+1), 32'hA000_0000 + 32'(2*i+1), 1, "R3 fill");
        end
        step(1, 1, 22'h3FFFFE, 1, 32'hE0E0_0001, 0, 0, '0, '0, -1, "R7 top");
        step(1, 1, 22'h3FFFFF, 1, 32'hE0E0_0002, 0, 0, '0, '0, -1, "R7 top");

        // R3: adjacent words in different banks; R6: same bank stalls port 1
        step(1, 0, 22'd0, 1, '0, 1, 0, 22'd1, '0, 1, "R3 parallel");
        step(1, 0, 22'd0, 1, '0, 1, 0, 22'd4, '0, 0, "R3 R6 conflict");
        step(0, 0, '0, 0, '0, 1, 0, 22'd4, '0, 1, "R6 retry");
        step(1, 0, 22'd8, 1, '0, 1, 0, 22'd12, '0, 0, "R6 stall a");
        step(1, 0, 22'd16, 1, '0, 1, 0, 22'd12, '0, 0, "R6 stall b");
        step(1, 0, 22'd17, 1, '0, 1, 0, 22'd12, '0, 1, "R6 release");

        // R7: bursts of each length, including row and address wrap
        step(1, 0, 22'd0, 4, '0, 0, 0, '0, '0, -1, "R7 b0x4");
        step(1, 0, 22'd2, 4, '0, 0, 0, '0, '0, -1, "R7 b2x4");
        step(1, 0, 22'd5, 3, '0, 0, 0, '0, '0, -1, "R7 b5x3");
        step(1, 0, 22'd7, 2, '0, 0, 0, '0, '0, -1, "R7 b7x2");
        step(1, 0, 22'd10, 1, '0, 0, 0, '0, '0, -1, "R7 b10x1");
        step(1, 0, 22'h3FFFFE, 4, '0, 0, 0, '0, '0, -1, "R7 wrap");

        // R9: port 1 beside a burst
        step(1, 0, 22'd1, 2, '0, 1, 0, 22'd3, '0, 1, "R9 free bank");
        step(1, 0, 22'd1, 2, '0, 1, 0, 22'd6, '0, 0, "R9 covered bank");
        step(1, 0, 22'd4, 4, '0, 1, 0, 22'd6, '0, 0, "R9 full burst");
        step(0, 0, '0, 0, '0, 1, 0, 22'd6, '0, 1, "R9 after burst");

        // R11: refused write leaves memory alone
        step(1, 0, 22'd8, 1, '0, 1, 1, 22'd12, 32'hDEAD_BEEF, 0, "R11 refused");
        idle();
        step(1, 0, 22'd12, 1, '0, 0, 0, '0, '0, -1, "R11 readback");

        // R5: write then immediate read; port 1 write then port 0 read
        step(1, 1, 22'd9, 1, 32'h5555_1234, 0, 0, '0, '0, -1, "R5 write");
        step(1, 0, 22'd9, 1, '0, 0, 0, '0, '0, -1, "R5 readback");
        step(0, 0, '0, 0, '0, 1, 1, 22'd14, 32'h7777_0014, 1, "R5 p1 write");
        step(1, 0, 22'd14, 1, '0, 0, 0, '0, '0, -1, "R5 p1 readback");

        // R10: switch to high-order; address 5 is bank 0 row 5 = old address 20
        set_mode(1'b0);
        idle();
        step(1, 0, 22'd5, 1, '0, 0, 0, '0, '0, -1, "R10 no remap");
        nchk++;
        if (mdl[phys(22'd5, 1'b0)] !== 32'hA000_0014) begin
            nfail++;
            $display("FAIL R10 model: actual %h expected a0000014", mdl[phys(22'd5, 1'b0)]);
        end

        // R2: high-order split
        step(1, 0, 22'd0, 1, '0, 1, 0, 22'd1, '0, 0, "R2 same bank");
        step(1, 0, 22'd0, 1, '0, 1, 0, 22'h100000, '0, 1, "R2 bank1 row0");
        step(1, 0, 22'h300002, 1, '0, 1, 0, 22'h200007, '0, 1, "R2 banks 3/2");
        step(1, 1, 22'h100003, 1, 32'hC0DE_0103, 0, 0, '0, '0, -1, "R2 write");

        // R8: burst length ignored in high-order mode
        step(1, 0, 22'd6, 4, '0, 0, 0, '0, '0, -1, "R8 single lane");
        step(1, 0, 22'd0, 4, '0, 1, 0, 22'h100001, '0, 1, "R8 one bank held");

        // R10/R2: back to low-order; bank 1 row 3 is address 13
        set_mode(1'b1);
        idle();
        step(1, 0, 22'd13, 1, '0, 0, 0, '0, '0, -1, "R10 R2 readback");
        nchk++;
        if (mdl[phys(22'd13, 1'b1)] !== 32'hC0DE_0103) begin
            nfail++;
            $display("FAIL R10 model: actual %h expected c0de0103", mdl[phys(22'd13, 1'b1)]);
        end
        idle();
        idle();
        idle();

        nchk++;
        if (q0.size() != 0 || q1.size() != 0) begin
            nfail++;
            $display("FAIL R4 drain: actual pending %0d/%0d expected 0/0", q0.size(), q1.size());
        end
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule